// File: doc/BRIEF.md
# Load-Use Interlock Stall Generator

This block decides, at the issue stage of a deep in-order integer pipeline with result forwarding, whether the instruction being offered may enter the pipeline now or must wait. It keeps a short record of the older instructions that are still in flight and have not yet produced a usable result. For each one it holds the destination register and whether the result comes from a load or from the ALU. It compares each source register of the offered instruction against that record. A source read as an ALU operand can take a result later than a source that forms a memory address, so the block handles the two kinds of use differently.

The wait depends on the kind of producer and the kind of use. An ALU result feeding an ALU operand costs nothing. A load result feeding an ALU operand costs two bubbles. An ALU result feeding an address costs one bubble. A load result feeding an address costs three bubbles. Each cycle that passes between the producer and the consumer removes one bubble from the cost, whether that cycle carries an unrelated instruction or a bubble. The block also reports, for each source, how many cycles ago its youngest producer issued. The forwarding multiplexers outside the block use this value. Zero means the register file holds the value.

Instructions are offered on a valid/ready handshake. An instruction is accepted in a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low, upstream must keep `iss_valid` high and every `iss_*` field unchanged. In each such cycle one bubble goes down the pipe. `iss_ready` returns high in the first cycle in which no hazard remains. If `iss_valid` is low, `iss_ready` is high.

Top module: `load_use_interlock`

## Requirements
- R1: An ALU result read as a data operand (source A or B) by the instruction accepted in the next cycle causes no stall.
- R2: A load result read as a data operand by the instruction accepted in the next cycle causes exactly 2 stall cycles.
- R3: An ALU result read as the address base by the instruction offered in the next cycle causes exactly 1 stall cycle.
- R4: A load result read as the address base by the instruction offered in the next cycle causes exactly 3 stall cycles.
- R5: For each source, the stall equals the cost from R1 to R4 plus one, minus the number of cycles since its producer was accepted, with a floor of zero. Accepted instructions and idle or bubble cycles both count toward the cycles since acceptance. The instruction waits for the largest stall over all its enabled sources.
- R6: Register 15 never creates a dependency, whether as a destination or as a source. An instruction with `iss_dst_en` low never creates a dependency.
- R7: When several in-flight instructions write the same register, only the youngest of them decides the stall and the forwarding select.
- R8: `stall` is high exactly in the cycles where `iss_valid` is high and `iss_ready` is low. The instruction is accepted in the first cycle in which no hazard remains.
- R9: In the cycle of acceptance, `fwd_a`, `fwd_b` and `fwd_base` each give the age of the youngest in-flight producer of that source. The age is 1 when the producer was accepted in the previous cycle and can be at most 3. The value is 0 when the source is disabled, is register 15, or has no producer within 3 cycles.
- R10: After reset nothing is in flight: `iss_ready` is high and every forwarding select reads 0.
- R11: An instruction held under the handshake rule never stalls for more than 3 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_ready | output | 1 | The offered instruction is accepted this cycle |
| iss_dst_en | input | 1 | The instruction writes a destination register |
| iss_dst | input | 4 | Destination register number |
| iss_is_load | input | 1 | The result comes from memory (load), not the ALU |
| iss_a_en | input | 1 | Source A is read as an ALU operand |
| iss_a | input | 4 | Source A register number |
| iss_b_en | input | 1 | Source B is read as an ALU operand |
| iss_b | input | 4 | Source B register number |
| iss_base_en | input | 1 | The base register is read to form a memory address |
| iss_base | input | 4 | Base register number |
| stall | output | 1 | A bubble is inserted this cycle |
| fwd_a | output | 2 | Age of the youngest producer of source A, 0 for the register file |
| fwd_b | output | 2 | Age of the youngest producer of source B, 0 for the register file |
| fwd_base | output | 2 | Age of the youngest producer of the base, 0 for the register file |

## Verification
The bound assertions check on every cycle the four cases where the consumer directly follows its producer (R1 to R4). They also check that register 15 never raises a stall and that no run of stall cycles grows longer than the largest cost. How the cost shrinks over intervening instructions and bubbles, the shadowing of an older producer by a younger one, and the forwarding ages can only be shown by the bench's sequences. The bench checks these against its own issue-cycle arithmetic. It sweeps every producer kind, use kind and gap, then runs a long random stream over a small register set and compares the total bubble count with the sum of the expected costs.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Cost in bubbles for a consumer directly behind its producer.
  function automatic int unsigned hz_lat(input logic is_ld, input logic addr_use,
                                         input int unsigned alu_data, input int unsigned ld_data,
                                         input int unsigned alu_addr, input int unsigned ld_addr);
    if (is_ld) return addr_use ? ld_addr : ld_data;
    return addr_use ? alu_addr : alu_data;
  endfunction

  function automatic int unsigned hz_max4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (m < 1) m = 1;
    return m;
  endfunction

endpackage

// File: rtl/hz_tracker.sv
// Shift record of in-flight producers, one slot per cycle of age.
module hz_tracker #(
  parameter int REG_W  = 4,
  parameter int DEPTH  = 3,
  parameter int PC_REG = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic                        push_ld,
  input  logic [REG_W-1:0]            push_rd,
  output logic [DEPTH-1:0]            slot_vld,
  output logic [DEPTH-1:0]            slot_ld,
  output logic [DEPTH-1:0][REG_W-1:0] slot_rd
);

  logic keep;
  assign keep = push && (push_rd != REG_W'(PC_REG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
      slot_ld  <= '0;
      slot_rd  <= '0;
    end else begin
      slot_vld[0] <= keep;
      slot_ld[0]  <= push_ld;
      slot_rd[0]  <= push_rd;
      for (int i = 1; i < DEPTH; i++) begin
        slot_vld[i] <= slot_vld[i-1];
        slot_ld[i]  <= slot_ld[i-1];
        slot_rd[i]  <= slot_rd[i-1];
      end
    end
  end

endmodule

// File: rtl/hz_source_check.sv
// Hazard and forwarding age for one source operand.
module hz_source_check
  import hz_pkg::*;
#(
  parameter int   REG_W         = 4,
  parameter int   DEPTH         = 3,
  parameter int   AGE_W         = 2,
  parameter bit   ADDR_USE      = 1'b0,
  parameter int   ALU_DATA_LAT  = 0,
  parameter int   LOAD_DATA_LAT = 2,
  parameter int   ALU_ADDR_LAT  = 1,
  parameter int   LOAD_ADDR_LAT = 3
) (
  input  logic                        en,
  input  logic [REG_W-1:0]            rs,
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0]            slot_ld,
  input  logic [DEPTH-1:0][REG_W-1:0] slot_rd,
  output logic                        haz,
  output logic [AGE_W-1:0]            age
);

  int unsigned lat;

  // Oldest first, so the youngest matching slot has the last word.
  always_comb begin
    haz = 1'b0;
    age = '0;
    lat = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (en && slot_vld[i] && (slot_rd[i] == rs)) begin
        lat = hz_lat(slot_ld[i], ADDR_USE, ALU_DATA_LAT, LOAD_DATA_LAT,
                     ALU_ADDR_LAT, LOAD_ADDR_LAT);
        age = AGE_W'(i + 1);
        haz = (int'(lat) > i);
      end
    end
  end

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import hz_pkg::*;
#(
  parameter  int REG_W         = 4,
  parameter  int PC_REG        = 15,
  parameter  int ALU_DATA_LAT  = 0,
  parameter  int LOAD_DATA_LAT = 2,
  parameter  int ALU_ADDR_LAT  = 1,
  parameter  int LOAD_ADDR_LAT = 3,
  localparam int DEPTH = int'(hz_max4(ALU_DATA_LAT, LOAD_DATA_LAT, ALU_ADDR_LAT, LOAD_ADDR_LAT)),
  localparam int AGE_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic             iss_dst_en,
  input  logic [REG_W-1:0] iss_dst,
  input  logic             iss_is_load,
  input  logic             iss_a_en,
  input  logic [REG_W-1:0] iss_a,
  input  logic             iss_b_en,
  input  logic [REG_W-1:0] iss_b,
  input  logic             iss_base_en,
  input  logic [REG_W-1:0] iss_base,
  output logic             stall,
  output logic [AGE_W-1:0] fwd_a,
  output logic [AGE_W-1:0] fwd_b,
  output logic [AGE_W-1:0] fwd_base
);

  localparam int NSRC = 3;

  logic [DEPTH-1:0]            s_vld;
  logic [DEPTH-1:0]            s_ld;
  logic [DEPTH-1:0][REG_W-1:0] s_rd;

  logic [NSRC-1:0]             src_en;
  logic [NSRC-1:0][REG_W-1:0]  src_rd;
  logic [NSRC-1:0]             src_haz;
  logic [NSRC-1:0][AGE_W-1:0]  src_age;
  logic                        fire;

  assign src_en = {iss_base_en, iss_b_en, iss_a_en};
  assign src_rd = {iss_base, iss_b, iss_a};

  hz_tracker #(
    .REG_W (REG_W),
    .DEPTH (DEPTH),
    .PC_REG(PC_REG)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (fire && iss_dst_en),
    .push_ld (iss_is_load),
    .push_rd (iss_dst),
    .slot_vld(s_vld),
    .slot_ld (s_ld),
    .slot_rd (s_rd)
  );

  // Slot NSRC-1 is the address base; the others are ALU operands.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_source_check #(
      .REG_W        (REG_W),
      .DEPTH        (DEPTH),
      .AGE_W        (AGE_W),
      .ADDR_USE     (g == NSRC - 1),
      .ALU_DATA_LAT (ALU_DATA_LAT),
      .LOAD_DATA_LAT(LOAD_DATA_LAT),
      .ALU_ADDR_LAT (ALU_ADDR_LAT),
      .LOAD_ADDR_LAT(LOAD_ADDR_LAT)
    ) u_chk (
      .en      (src_en[g]),
      .rs      (src_rd[g]),
      .slot_vld(s_vld),
      .slot_ld (s_ld),
      .slot_rd (s_rd),
      .haz     (src_haz[g]),
      .age     (src_age[g])
    );
  end

  assign stall     = iss_valid && (|src_haz);
  assign iss_ready = !stall;
  assign fire      = iss_valid && iss_ready;

  assign fwd_a    = src_age[0];
  assign fwd_b    = src_age[1];
  assign fwd_base = src_age[2];

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int REG_W         = 4,
  parameter int PC_REG        = 15,
  parameter int DEPTH         = 3,
  parameter int ALU_DATA_LAT  = 0,
  parameter int LOAD_DATA_LAT = 2,
  parameter int ALU_ADDR_LAT  = 1,
  parameter int LOAD_ADDR_LAT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             iss_dst_en,
  input logic [REG_W-1:0] iss_dst,
  input logic             iss_is_load,
  input logic             iss_a_en,
  input logic [REG_W-1:0] iss_a,
  input logic             iss_b_en,
  input logic [REG_W-1:0] iss_b,
  input logic             iss_base_en,
  input logic [REG_W-1:0] iss_base,
  input logic             stall
);

  logic           prev_ok;
  logic           prev_alu;
  logic           prev_ld;
  logic [REG_W-1:0] prev_dst;
  int             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ok  <= 1'b0;
      prev_alu <= 1'b0;
      prev_ld  <= 1'b0;
      prev_dst <= '0;
      run      <= 0;
    end else begin
      prev_ok  <= iss_valid && iss_ready && iss_dst_en && (iss_dst != REG_W'(PC_REG));
      prev_alu <= !iss_is_load;
      prev_ld  <= iss_is_load;
      prev_dst <= iss_dst;
      run      <= stall ? ((run < DEPTH + 1) ? run + 1 : run) : 0;
    end
  end

  p_alu_data_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && prev_alu && iss_valid && iss_a_en && (iss_a == prev_dst)
     && !iss_b_en && !iss_base_en) |-> (stall == (ALU_DATA_LAT > 0)));

  p_load_data_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && prev_ld && iss_valid && iss_a_en && (iss_a == prev_dst))
    |-> (stall || (LOAD_DATA_LAT == 0)));

  p_alu_addr_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && prev_alu && iss_valid && iss_base_en && (iss_base == prev_dst))
    |-> (stall || (ALU_ADDR_LAT == 0)));

  p_load_addr_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && prev_ld && iss_valid && iss_base_en && (iss_base == prev_dst))
    |-> (stall || (LOAD_ADDR_LAT == 0)));

  p_pc_no_dep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (!iss_a_en || iss_a == REG_W'(PC_REG))
     && (!iss_b_en || iss_b == REG_W'(PC_REG))
     && (!iss_base_en || iss_base == REG_W'(PC_REG))) |-> !stall);

  p_stall_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (run < DEPTH));

endmodule

bind load_use_interlock hz_interlock_chk #(
  .REG_W        (REG_W),
  .PC_REG       (PC_REG),
  .DEPTH        (DEPTH),
  .ALU_DATA_LAT (ALU_DATA_LAT),
  .LOAD_DATA_LAT(LOAD_DATA_LAT),
  .ALU_ADDR_LAT (ALU_ADDR_LAT),
  .LOAD_ADDR_LAT(LOAD_ADDR_LAT)
) u_hz_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_dst_en (iss_dst_en),
  .iss_dst    (iss_dst),
  .iss_is_load(iss_is_load),
  .iss_a_en   (iss_a_en),
  .iss_a      (iss_a),
  .iss_b_en   (iss_b_en),
  .iss_b      (iss_b),
  .iss_base_en(iss_base_en),
  .iss_base   (iss_base),
  .stall      (stall)
);

// File: tb/test_load_use_interlock.sv
module test_load_use_interlock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic       iss_ready;
  logic       iss_dst_en = 1'b0;
  logic [3:0] iss_dst = '0;
  logic       iss_is_load = 1'b0;
  logic       iss_a_en = 1'b0;
  logic [3:0] iss_a = '0;
  logic       iss_b_en = 1'b0;
  logic [3:0] iss_b = '0;
  logic       iss_base_en = 1'b0;
  logic [3:0] iss_base = '0;
  logic       stall;
  logic [1:0] fwd_a, fwd_b, fwd_base;

  always #10 clk = ~clk;

  load_use_interlock i_load_use_interlock (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_is_load(iss_is_load),
    .iss_a_en(iss_a_en), .iss_a(iss_a), .iss_b_en(iss_b_en), .iss_b(iss_b),
    .iss_base_en(iss_base_en), .iss_base(iss_base), .stall(stall),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_base(fwd_base)
  );

  int cyc;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  int n_chk = 0, n_bad = 0;
  int total_bub = 0, total_exp = 0;
  bit pv[16];
  bit pl[16];
  int pc[16];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Cost table: load/ALU producer x data/address use.
  function automatic int cost(input bit ld, input bit addr);
    if (ld) return addr ? 3 : 2;
    return addr ? 1 : 0;
  endfunction

  function automatic int need(input bit en, input int r, input bit addr, input int now);
    int n;
    if (!en || !pv[r]) return 0;
    n = cost(pl[r], addr) + 1 - (now - pc[r]);
    return (n > 0) ? n : 0;
  endfunction

  function automatic int fexp(input bit en, input int r, input int now);
    if (en && pv[r] && (now - pc[r]) <= 3) return now - pc[r];
    return 0;
  endfunction

  task automatic idle();
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic flush();
    repeat (5) idle();
  endtask

  task automatic issue(input bit den, input int dst, input bit ld,
                       input bit ae, input int a, input bit be, input int b,
                       input bit ce, input int c, input string req, output int bub);
    int c0, e, fc;
    @(negedge clk);
    iss_valid = 1'b1; iss_dst_en = den; iss_dst = 4'(dst); iss_is_load = ld;
    iss_a_en = ae; iss_a = 4'(a); iss_b_en = be; iss_b = 4'(b);
    iss_base_en = ce; iss_base = 4'(c);
    c0 = cyc;
    e = need(ae, a, 1'b0, c0);
    if (need(be, b, 1'b0, c0) > e) e = need(be, b, 1'b0, c0);
    if (need(ce, c, 1'b1, c0) > e) e = need(ce, c, 1'b1, c0);
    bub = 0;
    #1;
    while (!iss_ready && bub < 8) begin
      if (!stall) check("R8", "stall while held", int'(stall), 1);
      bub++;
      @(negedge clk);
      #1;
    end
    fc = cyc;
    check("R8", "stall at accept", int'(stall), 0);
    check(req, "bubbles", bub, e);
    check("R9", "fwd_a", int'(fwd_a), fexp(ae, a, fc));
    check("R9", "fwd_b", int'(fwd_b), fexp(be, b, fc));
    check("R9", "fwd_base", int'(fwd_base), fexp(ce, c, fc));
    total_bub += bub;
    total_exp += e;
    if (den && dst != 15) begin
      pv[dst] = 1'b1; pl[dst] = ld; pc[dst] = fc;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: got hung expected done");
    summary();
    $finish;
  end

  initial begin
    int bb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: empty after reset
    check("R10", "ready after reset", int'(iss_ready), 1);
    check("R10", "fwd_a after reset", int'(fwd_a), 0);
    check("R10", "fwd_base after reset", int'(fwd_base), 0);
    issue(0, 0, 0, 1, 5, 1, 6, 1, 7, "R10", bb);

    // R1..R5: every producer kind, use kind and gap
    for (int pk = 0; pk < 2; pk++) begin
      for (int ck = 0; ck < 3; ck++) begin
        for (int gap = 0; gap < 4; gap++) begin
          string rq;
          int f;
          if (ck == 2) rq = pk ? "R4" : "R3";
          else         rq = pk ? "R2" : "R1";
          flush();
          issue(1, 5, pk[0], 0, 0, 0, 0, 0, 0, rq, bb);
          for (int g = 0; g < gap; g++) issue(1, 8, 0, 0, 0, 0, 0, 0, 0, "R5", bb);
          issue(0, 0, 0, ck == 0, 5, ck == 1, 5, ck == 2, 5, rq, bb);
          f = cost(pk[0], ck == 2) - gap;
          check("R5", "bubbles vs formula", bb, (f > 0) ? f : 0);
        end
      end
    end

    // R5: an idle cycle also counts
    flush();
    issue(1, 5, 1, 0, 0, 0, 0, 0, 0, "R5", bb);
    idle();
    issue(0, 0, 0, 1, 5, 0, 0, 0, 0, "R5", bb);
    check("R5", "load, idle, data use", bb, 1);

    // R6: register 15 and no-destination producers
    flush();
    issue(1, 15, 1, 0, 0, 0, 0, 0, 0, "R6", bb);
    issue(0, 0, 0, 1, 15, 0, 0, 1, 15, "R6", bb);
    check("R6", "r15 dependency", bb, 0);
    issue(0, 6, 1, 0, 0, 0, 0, 0, 0, "R6", bb);
    issue(0, 0, 0, 0, 0, 0, 0, 1, 6, "R6", bb);
    check("R6", "no-destination dependency", bb, 0);

    // R7: youngest producer wins
    flush();
    issue(1, 3, 1, 0, 0, 0, 0, 0, 0, "R7", bb);
    issue(1, 3, 0, 0, 0, 0, 0, 0, 0, "R7", bb);
    issue(0, 0, 0, 1, 3, 0, 0, 0, 0, "R7", bb);
    check("R7", "ALU shadows load", bb, 0);
    flush();
    issue(1, 3, 0, 0, 0, 0, 0, 0, 0, "R7", bb);
    issue(1, 3, 1, 0, 0, 0, 0, 0, 0, "R7", bb);
    issue(0, 0, 0, 0, 0, 1, 3, 0, 0, "R7", bb);
    check("R7", "load shadows ALU", bb, 2);

    // R5/R11: three producers in flight at once
    flush();
    issue(1, 1, 1, 0, 0, 0, 0, 0, 0, "R11", bb);
    issue(1, 2, 1, 0, 0, 0, 0, 0, 0, "R11", bb);
    issue(1, 3, 0, 0, 0, 0, 0, 0, 0, "R11", bb);
    issue(0, 0, 0, 1, 2, 1, 3, 1, 1, "R11", bb);
    check("R11", "three producers", bb, 1);

    // R5: random stream on a small register set
    flush();
    for (int n = 0; n < 400; n++) begin
      int rr[4];
      for (int k = 0; k < 4; k++) begin
        rr[k] = $urandom_range(0, 4);
        if (rr[k] == 4) rr[k] = 15;
      end
      if ($urandom_range(0, 7) == 0) idle();
      issue($urandom_range(0, 3) != 0, rr[0], 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), rr[1], 1'($urandom_range(0, 1)), rr[2],
            1'($urandom_range(0, 1)), rr[3], "R5", bb);
    end
    check("R5", "total bubbles", total_bub, total_exp);

    summary();
    $finish;
  end

endmodule